// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a host bus and the register file of a 16-bit peripheral. In direct mode every 16-bit word of a 1 KiB window goes straight through to the register file at the same address. In indirect mode the host decodes only three words: the mode register, an address latch and a data port. Any internal register is then reached by loading the latch with the target address and reading or writing the data port. The mode register is reachable at offset 0x0 in both modes, so the host can always switch modes or request a reset.

The bridge also answers a fixed identification word at 0xFE without involving the register file. It runs the software reset: setting the reset bit drives a reset pulse of fixed length toward the internal logic. After the pulse the bridge returns to direct mode with the latch cleared. Values wider than 16 bits are handled as two word accesses, high half first at the lower address.

Top module: `ibr_top`

## Requirements
- R1: After the synchronous reset `host_rdata` is 0, `sw_rst` is low, and the mode register reads 0x0000, which means direct mode.
- R2: In direct mode a word access to any address other than 0x000 and 0xFE is passed to the register file in the same cycle at the same address, with `rf_rd` or `rf_wr` high for exactly that cycle. Read data appears on `host_rdata` one cycle after `host_rd`.
- R3: The mode register is at offset 0x000 in both modes and reads back what was written. Its bit 0 set to 1 selects indirect mode.
- R4: A read of 0xFE returns the parameter `ID_VALUE` (default 0x5A3C). A write there changes nothing and strobes nothing.
- R5: In indirect mode only offsets 0x000, 0x002 and 0x004 are decoded. Any other address reads as 0 and causes no register-file strobe, so a write there leaves the target register unchanged.
- R6: In indirect mode a write to 0x002 loads the address latch with the written value, bit 0 forced to 0 and only the low 10 bits kept. A read of 0x002 returns the latch.
- R7: In indirect mode an access to 0x004 reaches the register whose address is in the latch. The latch keeps its value across data-port accesses, so repeated reads hit the same register.
- R8: A data-port access with the latch at 0x000 reaches the mode register. With the latch at 0xFE it reaches the identification word.
- R9: Writing the mode register with bit 7 set drives `sw_rst` high for `RST_CYCLES` cycles (default 8). During that time the mode register reads with bit 7 set, writes are dropped, other addresses read 0 and nothing is strobed. After it the mode register is 0x0000 and the latch is 0.
- R10: A 32-bit value occupies two words: the upper half at address A and the lower half at A+2. The two accesses are forwarded independently and each keeps its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host word read strobe |
| host_wr | input | 1 | Host word write strobe |
| host_addr | input | 10 | Host byte address (bit 0 ignored) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_addr | output | 10 | Register-file byte address |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data, combinational from `rf_addr` |
| sw_rst | output | 1 | Software reset pulse to the internal logic |

## Verification
The assertions assume that the host never raises `host_rd` and `host_wr` in the same cycle. They also assume that `rf_rdata` settles within the cycle the strobe is seen. The stimulus holds to both: it issues one access at a time, with an idle cycle after each. The bench itself acts as the register file and answers reads from a plain array. Every host access is driven on the falling clock edge, so the decoded strobes and the latch are stable before the rising edge that registers them.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MODE,
        TGT_LATCH,
        TGT_ID,
        TGT_RF
    } tgt_e;

    localparam int OFS_MODE = 'h000;
    localparam int OFS_ADDR = 'h002;
    localparam int OFS_DATA = 'h004;
    localparam int OFS_ID   = 'h0FE;

    localparam int BIT_IND  = 0;
    localparam int BIT_SRST = 7;

    function automatic logic word_hit(input logic [15:0] a, input int ofs);
        return {a[15:1], 1'b0} == 16'(ofs);
    endfunction

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          indirect,
    input  logic          busy,
    input  logic [AW-1:0] host_addr,
    input  logic [AW-1:0] latch_q,
    output tgt_e          tgt,
    output logic [AW-1:0] eff_addr
);

    logic [15:0] ha;
    logic [15:0] la;

    assign ha = 16'(host_addr);
    assign la = 16'(latch_q);

    always_comb begin
        tgt      = TGT_NONE;
        eff_addr = host_addr;
        if (busy) begin
            if (word_hit(ha, OFS_MODE)) tgt = TGT_MODE;
        end else if (!indirect) begin
            if (word_hit(ha, OFS_MODE))      tgt = TGT_MODE;
            else if (word_hit(ha, OFS_ID))   tgt = TGT_ID;
            else                             tgt = TGT_RF;
        end else begin
            if (word_hit(ha, OFS_MODE))      tgt = TGT_MODE;
            else if (word_hit(ha, OFS_ADDR)) tgt = TGT_LATCH;
            else if (word_hit(ha, OFS_DATA)) begin
                eff_addr = latch_q;
                if (word_hit(la, OFS_MODE))    tgt = TGT_MODE;
                else if (word_hit(la, OFS_ID)) tgt = TGT_ID;
                else                           tgt = TGT_RF;
            end
        end
    end

endmodule

// File: rtl/ibr_mode_ctrl.sv
module ibr_mode_ctrl
    import ibr_pkg::*;
#(
    parameter int DW         = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_q,
    output logic          busy
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign busy = mode_q[BIT_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cnt    <= '0;
        end else if (busy) begin
            if (cnt == CW'(RST_CYCLES - 1)) begin
                mode_q <= '0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (wr_en) begin
            mode_q <= wdata;
            cnt    <= '0;
        end
    end

    assert_reset_ends_direct_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> mode_q == '0);

    assert_mode_write_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> mode_q == $past(wdata));

    assert_mode_held_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && wr_en) |=> (mode_q == $past(mode_q) || mode_q == '0));

endmodule

// File: rtl/ibr_addr_latch.sv
module ibr_addr_latch #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] latch_q
);

    always_ff @(posedge clk) begin
        if (rst || clr) latch_q <= '0;
        else if (wr_en) latch_q <= {wdata[AW-1:1], 1'b0};
    end

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clr) |=> $stable(latch_q));

    assert_latch_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> latch_q == '0);

endmodule

// File: rtl/ibr_top.sv
module ibr_top
    import ibr_pkg::*;
#(
    parameter int          AW         = 10,
    parameter int          DW         = 16,
    parameter int          RST_CYCLES = 8,
    parameter logic [15:0] ID_VALUE   = 16'h5A3C
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          rf_rd,
    output logic          rf_wr,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    input  logic [DW-1:0] rf_rdata,
    output logic          sw_rst
);

    tgt_e          tgt;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] latch_q;
    logic [DW-1:0] mode_q;
    logic          busy;
    logic [DW-1:0] rd_mux;

    ibr_mode_ctrl #(.DW(DW), .RST_CYCLES(RST_CYCLES)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (host_wr && tgt == TGT_MODE),
        .wdata  (host_wdata),
        .mode_q (mode_q),
        .busy   (busy)
    );

    ibr_addr_latch #(.AW(AW)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (busy),
        .wr_en   (host_wr && tgt == TGT_LATCH),
        .wdata   (host_wdata[AW-1:0]),
        .latch_q (latch_q)
    );

    ibr_decode #(.AW(AW)) u_dec (
        .indirect  (mode_q[BIT_IND]),
        .busy      (busy),
        .host_addr (host_addr),
        .latch_q   (latch_q),
        .tgt       (tgt),
        .eff_addr  (eff_addr)
    );

    assign rf_rd    = host_rd && tgt == TGT_RF;
    assign rf_wr    = host_wr && tgt == TGT_RF;
    assign rf_addr  = eff_addr;
    assign rf_wdata = host_wdata;
    assign sw_rst   = busy;

    always_comb begin
        case (tgt)
            TGT_MODE:  rd_mux = mode_q;
            TGT_LATCH: rd_mux = DW'(latch_q);
            TGT_ID:    rd_mux = DW'(ID_VALUE);
            TGT_RF:    rd_mux = rf_rdata;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assert_single_access_R2: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_wr));

    assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> (!rf_rd && !rf_wr));

    assert_port_uses_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q[BIT_IND] && (rf_rd || rf_wr)) |-> rf_addr == latch_q);

    assert_direct_same_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[BIT_IND] && (rf_rd || rf_wr)) |-> rf_addr == host_addr);

    assert_read_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && tgt == TGT_RF) |=> host_rdata == $past(rf_rdata));

endmodule

// File: tb/ibr_top_test.sv
module ibr_top_test;

    localparam int RST_N = 8;
    localparam logic [15:0] ID = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rf_rd, rf_wr;
    logic [9:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic [15:0] rf_rdata;
    logic        sw_rst;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [0:511];

    logic [15:0] m_mode  = '0;
    logic [9:0]  m_latch = '0;
    int          m_left  = 0;

    always #5 clk = ~clk;

    ibr_top uut (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .sw_rst(sw_rst)
    );

    assign rf_rdata = mem[rf_addr[9:1]];

    // 0 none, 1 mode, 2 latch, 3 id, 4 register file
    function automatic int kind(input logic [9:0] a);
        logic [9:0] w;
        w = a & 10'h3FE;
        if (m_left > 0) return (w == 0) ? 1 : 0;
        if (!m_mode[0]) return (w == 0) ? 1 : (w == 10'hFE) ? 3 : 4;
        if (w == 0) return 1;
        if (w == 2) return 2;
        if (w == 4) return (m_latch == 0) ? 1 : (m_latch == 10'hFE) ? 3 : 4;
        return 0;
    endfunction

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'hA000 ^ 16'(i);
    end

    // register file behind the bridge, plus the reference state
    always @(posedge clk) begin
        if (rf_wr) mem[rf_addr[9:1]] <= rf_wdata;
        if (rst) begin
            m_mode = '0; m_latch = '0; m_left = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_mode = '0;
        end else if (host_wr) begin
            case (kind(host_addr))
                1: begin
                    m_mode = host_wdata;
                    if (host_wdata[7]) begin m_left = RST_N; m_latch = '0; end
                end
                2: m_latch = host_wdata[9:0] & 10'h3FE;
                default: ;
            endcase
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of strobes and reset pulse
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            check("R5 rf_rd", 16'(rf_rd), 16'(host_rd && kind(host_addr) == 4));
            check("R5 rf_wr", 16'(rf_wr), 16'(host_wr && kind(host_addr) == 4));
            check("R9 sw_rst", 16'(sw_rst), 16'(m_left > 0));
        end
    end

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        check(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", host_rdata, 16'h0000);
        check("R1 sw_rst after reset", 16'(sw_rst), 16'h0000);
        rd(10'h000, 16'h0000, "R1 mode after reset");

        wr(10'h010, 16'h1234);
        rd(10'h010, 16'h1234, "R2 direct write/read");
        rd(10'h200, 16'hA100, "R2 direct default");
        rd(10'h0FE, ID, "R4 id read");
        wr(10'h0FE, 16'hFFFF);
        rd(10'h0FE, ID, "R4 id after write");

        wr(10'h220, 16'hDEAD);
        wr(10'h222, 16'hBEEF);
        rd(10'h220, 16'hDEAD, "R10 upper half");
        rd(10'h222, 16'hBEEF, "R10 lower half");
        check("R10 upper at low address", mem[9'h110], 16'hDEAD);

        wr(10'h000, 16'h0001);
        rd(10'h000, 16'h0001, "R3 mode readback");
        rd(10'h010, 16'h0000, "R5 undecoded read");
        wr(10'h030, 16'h7777);
        wr(10'h002, 16'h0011);
        rd(10'h002, 16'h0010, "R6 latch readback");
        rd(10'h004, 16'h1234, "R7 data port read 1");
        rd(10'h004, 16'h1234, "R7 data port read 2");
        wr(10'h004, 16'h5555);
        rd(10'h004, 16'h5555, "R7 data port write");
        rd(10'h002, 16'h0010, "R7 latch kept");
        wr(10'h002, 16'h00FE);
        rd(10'h004, ID, "R8 port to id");
        wr(10'h002, 16'h0000);
        rd(10'h004, 16'h0001, "R8 port to mode");

        wr(10'h000, 16'h0081);
        n = 0;
        while (sw_rst && n < 100) begin n++; @(negedge clk); end
        check("R9 pulse length", 16'(n), 16'(RST_N));
        rd(10'h000, 16'h0000, "R9 mode after reset");
        rd(10'h010, 16'h5555, "R9 direct after reset");
        rd(10'h030, 16'hA018, "R5 ignored write");

        wr(10'h000, 16'h0001);
        wr(10'h002, 16'h0040);
        wr(10'h000, 16'h0081);
        rd(10'h000, 16'h0081, "R9 mode during reset");
        rd(10'h010, 16'h0000, "R9 other read during reset");
        wr(10'h000, 16'h0001);
        while (sw_rst) @(negedge clk);
        rd(10'h000, 16'h0000, "R9 write dropped in reset");
        wr(10'h000, 16'h0001);
        rd(10'h002, 16'h0000, "R9 latch cleared");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule